// File: doc/BRIEF.md
# Three-Source Combined Pseudo-Random Word Generator

This block produces one 32-bit pseudo-random word for each advance strobe by adding together the outputs of three independent generators that run side by side. The first is a xorshift register. The second is an additive counter that steps by a fixed odd increment. The third is an add-with-carry pair. It keeps a 31-bit word plus a carry bit and takes its new carry from the top bit of a 32-bit sum. The sequence is fully repeatable from the seeds. This suits test-pattern generation, dithering and randomised arbitration, where the same run must be reproducible.

Reset loads fixed nonzero seeds into every state word. A seed-load port replaces all state words at once. All three generators step together on one clock edge when advance is high. The result is registered, and a one-cycle valid pulse marks each new word.

Top module: `tri_rng`

## Requirements
- R1: While rst_ni is low and after its release, the state holds the seed parameters, rand_o is 0 and valid_o is 0.
- R2: On an advance, the xorshift word y becomes the result of three steps applied in this order on 32-bit logical shifts: y ^= y << 5, then y ^= y >> 7, then y ^= y << 22.
- R3: On an advance, the add-with-carry stage forms t = z + w + c modulo 2^32. z takes the old w, the new c is bit 31 of t, and the new w is t with bit 31 cleared. Bit 31 of w is therefore always 0.
- R4: On an advance, the counter x increases by 1411392427 modulo 2^32.
- R5: The cycle after an advance, rand_o equals x + y + w modulo 2^32, using the updated values of all three, and valid_o is 1 for exactly that cycle.
- R6: In a cycle without advance or seed load, no state word changes, rand_o keeps its value and valid_o is 0 in the next cycle.
- R7: A seed load replaces x, y, z, w and c from the seed inputs. Bit 31 of the loaded w is cleared, and c takes bit 0 of seed_c_i. The load leaves rand_o unchanged and valid_o is 0 in the next cycle.
- R8: When seed load and advance are high in the same cycle, the load wins and the advance is dropped: the state is exactly the loaded seeds and no new word is produced.
- R9: A seed load with a zero y value stores the default y seed instead, so the xorshift word is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset to the seed parameters |
| advance_i | input | 1 | Step all generators and produce one word |
| seed_load_i | input | 1 | Load all state words from the seed inputs |
| seed_x_i | input | 32 | Counter seed |
| seed_y_i | input | 32 | Xorshift seed (zero is replaced) |
| seed_z_i | input | 32 | Add-with-carry previous-word seed |
| seed_w_i | input | 32 | Add-with-carry word seed (bit 31 dropped) |
| seed_c_i | input | 1 | Add-with-carry carry seed |
| rand_o | output | 32 | Last generated word |
| valid_o | output | 1 | One-cycle pulse when rand_o is new |

## Verification
Seed load and advance can be asserted together, and the design must then keep only the load. The bench raises both strobes in directed cycles and also in random cycles, where each has an independent chance. It judges the outcome in two ways. First, the next cycle must show no valid pulse and an unchanged word. Second, the word after the following advance must match a model that started from the freshly loaded seeds, with no extra step applied. A zero y seed in the same cycle as an advance is also provoked, to confirm the substitution happens on the load path.

// File: rtl/tri_rng_pkg.sv
package tri_rng_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t x;
    word_t y;
    word_t z;
    word_t w;
    logic  c;
  } rng_state_t;
endpackage

// File: rtl/xorshift_stage.sv
module xorshift_stage #(
  parameter int unsigned W  = 32,
  parameter int unsigned SA = 5,
  parameter int unsigned SB = 7,
  parameter int unsigned SC = 22
) (
  input  logic [W-1:0] y_i,
  output logic [W-1:0] y_o
);
  localparam int unsigned NSTEP = 3;
  localparam int unsigned SHIFTS [NSTEP] = '{SA, SB, SC};

  logic [W-1:0] st [NSTEP+1];
  assign st[0] = y_i;

  // step 1 shifts right, steps 0 and 2 shift left; order is significant
  for (genvar g = 0; g < NSTEP; g++) begin : g_step
    if (g == 1) begin : g_right
      assign st[g+1] = st[g] ^ (st[g] >> SHIFTS[g]);
    end else begin : g_left
      assign st[g+1] = st[g] ^ (st[g] << SHIFTS[g]);
    end
  end

  assign y_o = st[NSTEP];
endmodule

// File: rtl/awc_stage.sv
module awc_stage #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] z_i,
  input  logic [W-1:0] w_i,
  input  logic         c_i,
  output logic [W-1:0] z_o,
  output logic [W-1:0] w_o,
  output logic         c_o
);
  logic [W-1:0] t;

  assign t   = z_i + w_i + {{(W-1){1'b0}}, c_i};
  assign z_o = w_i;
  assign c_o = t[W-1];
  assign w_o = {1'b0, t[W-2:0]};
endmodule

// File: rtl/weyl_stage.sv
module weyl_stage #(
  parameter int unsigned W   = 32,
  parameter logic [W-1:0] INC = 32'd1411392427
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] x_o
);
  assign x_o = x_i + INC;
endmodule

// File: rtl/tri_rng.sv
module tri_rng
  import tri_rng_pkg::*;
#(
  parameter logic [WORD_W-1:0] WEYL_INC = 32'd1411392427,
  parameter logic [WORD_W-1:0] SEED_X   = 32'd123456789,
  parameter logic [WORD_W-1:0] SEED_Y   = 32'd234567891,
  parameter logic [WORD_W-1:0] SEED_Z   = 32'd345678912,
  parameter logic [WORD_W-1:0] SEED_W   = 32'd456789123,
  parameter logic              SEED_C   = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              advance_i,
  input  logic              seed_load_i,
  input  logic [WORD_W-1:0] seed_x_i,
  input  logic [WORD_W-1:0] seed_y_i,
  input  logic [WORD_W-1:0] seed_z_i,
  input  logic [WORD_W-1:0] seed_w_i,
  input  logic              seed_c_i,
  output logic [WORD_W-1:0] rand_o,
  output logic              valid_o
);
  localparam int unsigned W = WORD_W;
  localparam word_t W_MASK = {1'b0, {(W-1){1'b1}}};
  localparam rng_state_t RESET_ST = '{x: SEED_X, y: SEED_Y, z: SEED_Z,
                                      w: SEED_W & W_MASK, c: SEED_C};

  rng_state_t st_q, st_d, step_st, load_st;
  word_t      x_q, y_q, w_q;
  word_t      rand_q;
  logic       valid_q;
  logic       do_step;

  assign x_q = st_q.x;
  assign y_q = st_q.y;
  assign w_q = st_q.w;

  xorshift_stage #(.W(W), .SA(5), .SB(7), .SC(22)) u_xs (
    .y_i(st_q.y),
    .y_o(step_st.y)
  );

  awc_stage #(.W(W)) u_awc (
    .z_i(st_q.z),
    .w_i(st_q.w),
    .c_i(st_q.c),
    .z_o(step_st.z),
    .w_o(step_st.w),
    .c_o(step_st.c)
  );

  weyl_stage #(.W(W), .INC(WEYL_INC)) u_weyl (
    .x_i(st_q.x),
    .x_o(step_st.x)
  );

  always_comb begin
    load_st.x = seed_x_i;
    load_st.y = (seed_y_i == '0) ? SEED_Y : seed_y_i;
    load_st.z = seed_z_i;
    load_st.w = seed_w_i & W_MASK;
    load_st.c = seed_c_i;
  end

  // load has priority over advance
  assign do_step = advance_i && !seed_load_i;

  always_comb begin
    st_d = st_q;
    if (seed_load_i)  st_d = load_st;
    else if (do_step) st_d = step_st;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RESET_ST;
      rand_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      valid_q <= do_step;
      if (do_step) rand_q <= step_st.x + step_st.y + step_st.w;
    end
  end

  assign rand_o  = rand_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/tri_rng_chk.sv
module tri_rng_chk #(
  parameter int unsigned  W   = 32,
  parameter logic [W-1:0] INC = 32'd1411392427
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         advance_i,
  input logic         seed_load_i,
  input logic [W-1:0] seed_x_i,
  input logic [W-1:0] rand_o,
  input logic         valid_o,
  input logic [W-1:0] x_q,
  input logic [W-1:0] y_q,
  input logic [W-1:0] w_q
);
  p_w_31bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_q[W-1] == 1'b0);

  p_weyl_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i && !seed_load_i |=> x_q == $past(x_q) + INC);

  p_valid_after_adv_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i && !seed_load_i |=> valid_o);

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !advance_i && !seed_load_i |=> !valid_o && $stable(rand_o) && $stable(x_q));

  p_load_x_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i |=> x_q == $past(seed_x_i));

  p_load_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i |=> !valid_o && $stable(rand_o));

  p_y_nonzero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_q != '0);
endmodule

bind tri_rng tri_rng_chk #(.W(W), .INC(WEYL_INC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .advance_i  (advance_i),
  .seed_load_i(seed_load_i),
  .seed_x_i   (seed_x_i),
  .rand_o     (rand_o),
  .valid_o    (valid_o),
  .x_q        (x_q),
  .y_q        (y_q),
  .w_q        (w_q)
);

// File: tb/tri_rng_test.sv
module tri_rng_test;
  localparam logic [31:0] INC  = 32'd1411392427;
  localparam logic [31:0] DX   = 32'd123456789;
  localparam logic [31:0] DY   = 32'd234567891;
  localparam logic [31:0] DZ   = 32'd345678912;
  localparam logic [31:0] DW   = 32'd456789123;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        advance_i = 1'b0, seed_load_i = 1'b0, seed_c_i = 1'b0;
  logic [31:0] seed_x_i = '0, seed_y_i = '0, seed_z_i = '0, seed_w_i = '0;
  logic [31:0] rand_o;
  logic        valid_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_x, m_y, m_z, m_w, m_out;
  logic        m_c, m_valid;

  always #4 clk = ~clk;

  tri_rng uut (
    .clk_i(clk), .rst_ni(rst_ni), .advance_i(advance_i), .seed_load_i(seed_load_i),
    .seed_x_i(seed_x_i), .seed_y_i(seed_y_i), .seed_z_i(seed_z_i),
    .seed_w_i(seed_w_i), .seed_c_i(seed_c_i), .rand_o(rand_o), .valid_o(valid_o)
  );

  function automatic logic [31:0] xs(input logic [31:0] y);
    y = y ^ (y << 5);
    y = y ^ (y >> 7);
    y = y ^ (y << 22);
    return y;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_x = DX; m_y = DY; m_z = DZ; m_w = DW; m_c = 1'b0; m_out = '0; m_valid = 1'b0;
  endtask

  // R2 R3 R4 model step
  task automatic model_cycle(input bit adv, input bit ld, input logic [31:0] sx,
      input logic [31:0] sy, input logic [31:0] sz, input logic [31:0] sw, input bit sc);
    logic [31:0] t;
    if (ld) begin
      m_x = sx; m_y = (sy == 0) ? DY : sy; m_z = sz; m_w = {1'b0, sw[30:0]}; m_c = sc;
      m_valid = 1'b0;
    end else if (adv) begin
      m_y = xs(m_y);
      t = m_z + m_w + {31'd0, m_c};
      m_z = m_w; m_c = t[31]; m_w = {1'b0, t[30:0]};
      m_x = m_x + INC;
      m_out = m_x + m_y + m_w;
      m_valid = 1'b1;
    end else begin
      m_valid = 1'b0;
    end
  endtask

  // called at a negedge; returns at the next negedge after comparing
  task automatic cyc(input string req, input bit adv, input bit ld,
      input logic [31:0] sx, input logic [31:0] sy, input logic [31:0] sz,
      input logic [31:0] sw, input bit sc);
    advance_i = adv; seed_load_i = ld;
    seed_x_i = sx; seed_y_i = sy; seed_z_i = sz; seed_w_i = sw; seed_c_i = sc;
    model_cycle(adv, ld, sx, sy, sz, sw, sc);
    @(negedge clk);
    chk({req, " word"}, rand_o, m_out);
    chk({req, " valid"}, {31'd0, valid_o}, {31'd0, m_valid});
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 word in reset", rand_o, 32'd0);
    chk("R1 valid in reset", {31'd0, valid_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 word after reset", rand_o, 32'd0);
    // first words come from the reset seeds (R1 R2 R3 R4 R5)
    cyc("R5 first", 1, 0, 0, 0, 0, 0, 0);
    cyc("R2 second", 1, 0, 0, 0, 0, 0, 0);
    cyc("R4 third", 1, 0, 0, 0, 0, 0, 0);
    // idle holds (R6)
    cyc("R6 idle", 0, 0, 32'hffff_ffff, 32'h1, 0, 0, 1);
    cyc("R6 idle2", 0, 0, 0, 0, 0, 0, 0);
    cyc("R6 after idle", 1, 0, 0, 0, 0, 0, 0);
    // load with w bit31 set and carry in, x near wrap (R7 R3 R4)
    cyc("R7 load", 0, 1, 32'hffff_fff0, 32'h0000_0001, 32'hffff_ffff, 32'hffff_ffff, 1);
    cyc("R3 carry step", 1, 0, 0, 0, 0, 0, 0);
    cyc("R3 carry step2", 1, 0, 0, 0, 0, 0, 0);
    // load and advance together (R8)
    cyc("R8 load+adv", 1, 1, 32'h1234_5678, 32'h8000_0000, 32'h0, 32'h7fff_ffff, 0);
    cyc("R8 next step", 1, 0, 0, 0, 0, 0, 0);
    // zero y seed, with advance also high (R9)
    cyc("R9 zero y", 1, 1, 32'd5, 32'd0, 32'd6, 32'd7, 0);
    cyc("R9 step", 1, 0, 0, 0, 0, 0, 0);
    cyc("R9 step2", 1, 0, 0, 0, 0, 0, 0);
    // constrained random mix (R5 R6 R7 R8)
    for (int i = 0; i < 4000; i++) begin
      bit adv, ld;
      logic [31:0] sy;
      adv = ($urandom_range(0, 3) != 0);
      ld  = ($urandom_range(0, 31) == 0);
      sy  = ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom;
      cyc("R5 random", adv, ld, $urandom, sy, $urandom, $urandom, 1'($urandom));
    end
    advance_i = 1'b0; seed_load_i = 1'b0;
    done = 1;
    summary();
    $finish;
  end
endmodule